// File: doc/BRIEF.md
# Addressed Fixed-Length Packet Filter

This block sits behind a serial byte receiver and picks out the packets meant for this node. Bytes come in on a valid/ready stream. A packet has a fixed number of bytes. Its first byte must carry this node's identifier and its second byte must carry the identifier of the one sender this node listens to. Any stream that breaks that two-byte header is thrown away at once, and the filter goes back to hunting for a new first byte. Once a header matches, the rest of the bytes are stored in order. When the last byte arrives, the block raises a packet-ready flag and steps an 8-bit packet counter.

The packet stays in the internal buffer until the consumer acknowledges it. The consumer reads the stored bytes by index through a combinational read port. Until the acknowledge, further incoming bytes are discarded and a sticky drop flag records the loss. The stream side never applies back-pressure: `in_ready` is held high, every cycle with `in_valid` high is a transfer, and a byte that cannot be kept is dropped rather than stalled.

Top module: `pkt_addr_filter`

## Requirements
- R1: After reset `pkt_ready` and `drop_flag` are 0, `pkt_count` is 0 and every buffer slot reads 0.
- R2: While hunting (position 0), a byte not equal to `my_id` is discarded, the buffer is left unchanged and the filter stays at position 0.
- R3: At position 1, a byte not equal to the sender identifier captured at position 0 sends the filter back to position 0. That byte is not itself tested as a new first byte, and the buffer is left unchanged.
- R4: In an accepted packet, the k-th byte (counting the header as bytes 0 and 1) is stored in slot k. `rd_data` shows slot `rd_idx` in the same cycle.
- R5: On the clock edge that accepts byte PKT_LEN-1 of a packet, `pkt_ready` goes high and `pkt_count` increases by 1 modulo 256, so 255 wraps to 0. The count changes at no other time.
- R6: `pkt_ready` stays high until a cycle with `pkt_ack` high, and it is low from the following edge.
- R7: While `pkt_ready` is high and `pkt_ack` is low, every transferred byte is dropped, leaving the buffer and the filter position unchanged, and `drop_flag` is set from the next edge. `drop_flag` is cleared only by `pkt_ack`.
- R8: `in_ready` is 1 in every cycle after reset, and a byte transfers in each cycle where `in_valid` is high.
- R9: PKT_LEN is a parameter. Lengths of 16 and 64 both work, with `rd_idx` being clog2(PKT_LEN) bits wide.
- R10: A byte that arrives in the same cycle as `pkt_ack` is handled as if no packet were pending.
- R11: `peer_id` is sampled when the first header byte is accepted. Later changes to it do not affect the packet in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Incoming byte is valid |
| in_data | input | 8 | Incoming byte |
| in_ready | output | 1 | Always 1; the block drops bytes instead of stalling |
| my_id | input | 8 | This node's identifier, expected in header byte 0 |
| peer_id | input | 8 | Accepted sender identifier, expected in header byte 1 |
| pkt_ack | input | 1 | Consumer has taken the packet; clears the ready and drop flags |
| pkt_ready | output | 1 | A complete packet is held in the buffer |
| drop_flag | output | 1 | Bytes were discarded while a packet was pending |
| pkt_count | output | 8 | Completed packets, wrapping modulo 256 |
| rd_idx | input | clog2(PKT_LEN) | Buffer slot to read |
| rd_data | output | 8 | Content of slot `rd_idx` |

## Verification
The bench aims at the header edges. It sends a second byte that mismatches but is followed by a valid-looking payload; a filter that re-tested that byte or kept counting would complete a packet too early. It sends bytes while a packet is pending, where a wrong design would overwrite slots or restart framing and corrupt the packet the consumer is reading. It also places an acknowledge in the same cycle as a new header byte, changes the sender input mid-packet, and drives the counter through its 255-to-0 wrap. Both the 16-byte and the 64-byte builds are compared against a behavioural model on every clock, which exposes an off-by-one completion position.

// File: rtl/pkt_filter_pkg.sv
package pkt_filter_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef enum logic [1:0] {SLOT_DEST, SLOT_SRC, SLOT_BODY} slot_e;
endpackage

// File: rtl/pkt_frame_ctrl.sv
module pkt_frame_ctrl
  import pkt_filter_pkg::*;
#(
  parameter int PKT_LEN = 64,
  localparam int IDX_W = $clog2(PKT_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  byte_t            data,
  input  byte_t            my_id,
  input  byte_t            peer_id,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_pos,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(PKT_LEN - 1);

  logic [IDX_W-1:0] pos;
  byte_t            peer_q;
  slot_e            slot;

  always_comb begin
    if (pos == '0)                slot = SLOT_DEST;
    else if (pos == IDX_W'(1))    slot = SLOT_SRC;
    else                          slot = SLOT_BODY;
  end

  always_comb begin
    wr_en = 1'b0;
    done  = 1'b0;
    if (take) begin
      unique case (slot)
        SLOT_DEST: wr_en = (data == my_id);
        SLOT_SRC:  wr_en = (data == peer_q);
        default: begin
          wr_en = 1'b1;
          done  = (pos == LAST);
        end
      endcase
    end
  end

  assign wr_pos = pos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos    <= '0;
      peer_q <= '0;
    end else if (take) begin
      if (slot == SLOT_DEST && wr_en) peer_q <= peer_id;
      if (!wr_en || done) pos <= '0;
      else                pos <= pos + IDX_W'(1);
    end
  end

  // R3
  src_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && slot == SLOT_SRC && data != peer_q) |=> (pos == '0));

  // R4
  body_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && slot == SLOT_BODY && pos != LAST) |=> (pos == $past(pos) + IDX_W'(1)));

  // R2
  dest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && slot == SLOT_DEST && data != my_id) |=> (pos == '0));
endmodule

// File: rtl/pkt_byte_store.sv
module pkt_byte_store
  import pkt_filter_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_pos,
  input  byte_t            wr_data,
  input  logic [IDX_W-1:0] rd_pos,
  output byte_t            rd_data
);
  byte_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_pos] <= wr_data;
    end
  end

  assign rd_data = (int'(rd_pos) < DEPTH) ? mem[rd_pos] : '0;

  // R4
  wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_pos) < DEPTH));
endmodule

// File: rtl/pkt_addr_filter.sv
module pkt_addr_filter
  import pkt_filter_pkg::*;
#(
  parameter int PKT_LEN = 64,
  localparam int IDX_W = $clog2(PKT_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  input  logic [7:0]       my_id,
  input  logic [7:0]       peer_id,
  input  logic             pkt_ack,
  output logic             pkt_ready,
  output logic             drop_flag,
  output logic [7:0]       pkt_count,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);
  logic             pending;
  logic             take;
  logic             wr_en;
  logic             done;
  logic [IDX_W-1:0] wr_pos;

  assign in_ready = 1'b1;
  assign pending  = pkt_ready & ~pkt_ack;
  assign take     = in_valid & ~pending;

  pkt_frame_ctrl #(.PKT_LEN(PKT_LEN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .take(take), .data(in_data),
    .my_id(my_id), .peer_id(peer_id),
    .wr_en(wr_en), .wr_pos(wr_pos), .done(done)
  );

  pkt_byte_store #(.DEPTH(PKT_LEN)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_pos(wr_pos),
    .wr_data(in_data), .rd_pos(rd_idx), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_ready <= 1'b0;
      drop_flag <= 1'b0;
      pkt_count <= '0;
    end else begin
      if (pkt_ack) begin
        pkt_ready <= 1'b0;
        drop_flag <= 1'b0;
      end
      if (in_valid && pending) drop_flag <= 1'b1;
      if (done) begin
        pkt_ready <= 1'b1;
        pkt_count <= pkt_count + 8'd1;
      end
    end
  end

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_count != $past(pkt_count)) |-> (pkt_ready && pkt_count == $past(pkt_count) + 8'd1));

  // R5
  done_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> pkt_ready);

  // R6
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_ready && !pkt_ack) |=> pkt_ready);

  // R6
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_ready && pkt_ack) |=> !pkt_ready);

  // R7
  drop_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_ready && !pkt_ack && in_valid) |=> drop_flag);

  // R7
  frozen_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_ready && !pkt_ack) |-> !wr_en);
endmodule

// File: tb/pkt_addr_filter_test.sv
module filter_model #(parameter int LEN = 16) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       v,
  input  logic [7:0] d,
  input  logic [7:0] my,
  input  logic [7:0] peer,
  input  logic       ack,
  input  int         rd,
  output logic       rdy,
  output logic       ovf,
  output logic [7:0] cnt,
  output logic [7:0] rdd
);
  int         pos;
  logic [7:0] mem [LEN];
  logic [7:0] peer_seen;

  always @(posedge clk) begin : step
    bit pend;
    if (!rst_n) begin
      pos = 0; rdy = 0; ovf = 0; cnt = 0; peer_seen = 0;
      for (int i = 0; i < LEN; i++) mem[i] = 0;
    end else begin
      pend = rdy && !ack;
      if (ack) begin rdy = 0; ovf = 0; end
      if (v) begin
        if (pend) ovf = 1;
        else if (pos == 0) begin
          if (d == my) begin mem[0] = d; peer_seen = peer; pos = 1; end
        end else if (pos == 1) begin
          if (d == peer_seen) begin mem[1] = d; pos = 2; end
          else pos = 0;
        end else begin
          mem[pos] = d;
          if (pos == LEN - 1) begin pos = 0; rdy = 1; cnt = cnt + 8'd1; end
          else pos = pos + 1;
        end
      end
    end
  end

  assign rdd = (rd < LEN) ? mem[rd] : 8'h00;
endmodule

module pkt_addr_filter_test;
  logic       clk = 1'b0;
  logic       rst_n, in_valid, pkt_ack;
  logic [7:0] in_data, my_id, peer_id;
  logic [5:0] rd_sel;
  logic       rdy16, drop16, inr16, rdy64, drop64, inr64;
  logic [7:0] cnt16, cnt64, rd16, rd64;
  logic       m_rdy16, m_ovf16, m_rdy64, m_ovf64;
  logic [7:0] m_cnt16, m_cnt64, m_rd16, m_rd64;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pkt_addr_filter #(.PKT_LEN(16)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(inr16),
    .my_id(my_id), .peer_id(peer_id), .pkt_ack(pkt_ack), .pkt_ready(rdy16),
    .drop_flag(drop16), .pkt_count(cnt16), .rd_idx(rd_sel[3:0]), .rd_data(rd16));

  pkt_addr_filter #(.PKT_LEN(64)) uut_long (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(inr64),
    .my_id(my_id), .peer_id(peer_id), .pkt_ack(pkt_ack), .pkt_ready(rdy64),
    .drop_flag(drop64), .pkt_count(cnt64), .rd_idx(rd_sel), .rd_data(rd64));

  filter_model #(.LEN(16)) m16 (.clk(clk), .rst_n(rst_n), .v(in_valid), .d(in_data), .my(my_id),
    .peer(peer_id), .ack(pkt_ack), .rd(int'(rd_sel[3:0])), .rdy(m_rdy16), .ovf(m_ovf16),
    .cnt(m_cnt16), .rdd(m_rd16));
  filter_model #(.LEN(64)) m64 (.clk(clk), .rst_n(rst_n), .v(in_valid), .d(in_data), .my(my_id),
    .peer(peer_id), .ack(pkt_ack), .rd(int'(rd_sel)), .rdy(m_rdy64), .ovf(m_ovf64),
    .cnt(m_cnt64), .rdd(m_rd64));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    chk("R6 pkt_ready len16", rdy16, m_rdy16);
    chk("R7 drop_flag len16", drop16, m_ovf16);
    chk("R5 pkt_count len16", cnt16, m_cnt16);
    chk("R4 rd_data len16", rd16, m_rd16);
    chk("R9 pkt_ready len64", rdy64, m_rdy64);
    chk("R9 drop_flag len64", drop64, m_ovf64);
    chk("R9 pkt_count len64", cnt64, m_cnt64);
    chk("R9 rd_data len64", rd64, m_rd64);
    chk("R8 in_ready", inr16 & inr64, 1);
  endtask

  task automatic send(input logic [7:0] b);
    in_valid = 1'b1; in_data = b;
    cyc();
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic ack_pulse();
    pkt_ack = 1'b1; cyc(); pkt_ack = 1'b0;
  endtask

  task automatic send_pkt(input int len, input logic [7:0] seed);
    send(my_id); send(peer_id);
    for (int k = 2; k < len; k++) send(seed + 8'(k));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; idle(2); rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int base;
    rst_n = 0; in_valid = 0; in_data = 0; pkt_ack = 0; rd_sel = 0;
    my_id = 8'h3C; peer_id = 8'hA7;
    idle(2); rst_n = 1'b1; idle(1);
    // R1 reset state
    chk("R1 pkt_ready", rdy16, 0); chk("R1 drop_flag", drop16, 0);
    chk("R1 pkt_count", cnt16, 0); chk("R1 rd_data", rd16, 0);

    // R2 wrong first byte ignored
    send(8'h55); send(8'hA7);
    for (int k = 2; k < 16; k++) send(8'(k));
    chk("R2 no packet after bad first byte", rdy16, 0);
    chk("R2 slot0 untouched", rd16, 0);
    idle(1);
    do_reset();
    send_pkt(16, 8'h40);
    chk("R5 ready after 16 bytes", rdy16, 1);
    chk("R5 count after first packet", cnt16, 1);
    // R4 readback
    for (int k = 0; k < 16; k++) begin
      rd_sel = 6'(k); #1;
      chk("R4 readback slot", rd16, (k == 0) ? 8'h3C : (k == 1) ? 8'hA7 : 8'h40 + k);
    end
    // R7 drop while pending
    send(8'h3C); send(8'hA7); send(8'hEE);
    chk("R7 drop_flag set", drop16, 1);
    rd_sel = 6'd15; #1;
    chk("R7 last slot unchanged", rd16, 8'h4F);
    chk("R7 count unchanged", cnt16, 1);
    idle(4);
    chk("R6 ready held", rdy16, 1);
    ack_pulse();
    chk("R6 ready cleared", rdy16, 0);
    chk("R7 drop cleared by ack", drop16, 0);

    // R3 sender mismatch restarts
    send(8'h3C); send(8'h11);
    for (int k = 2; k < 16; k++) send(8'h80 + 8'(k));
    chk("R3 no packet after bad second byte", rdy16, 0);
    chk("R3 count unchanged", cnt16, 1);
    send_pkt(16, 8'h10);
    chk("R3 recovers on next header", cnt16, 2);

    // R10 ack with first header byte
    pkt_ack = 1'b1; in_valid = 1'b1; in_data = 8'h3C; cyc();
    pkt_ack = 1'b0; in_valid = 1'b0;
    send(8'hA7);
    for (int k = 2; k < 16; k++) send(8'h20 + 8'(k));
    chk("R10 header taken with ack", cnt16, 3);
    chk("R10 ready", rdy16, 1);
    ack_pulse();

    // R11 peer change mid packet
    send(8'h3C); peer_id = 8'h99; send(8'hA7);
    for (int k = 2; k < 16; k++) send(8'(k));
    chk("R11 sampled sender used", cnt16, 4);
    ack_pulse(); peer_id = 8'hA7;

    // R9 64-byte build
    do_reset();
    send_pkt(64, 8'h00);
    chk("R9 len64 ready", rdy64, 1);
    chk("R9 len64 count", cnt64, 1);
    rd_sel = 6'd63; #1;
    chk("R9 len64 last slot", rd64, 63);
    ack_pulse();

    // R5 wrap
    do_reset();
    for (int p = 0; p < 255; p++) begin send_pkt(16, 8'(p)); ack_pulse(); end
    chk("R5 count at 255", cnt16, 255);
    send_pkt(16, 8'h01);
    chk("R5 count wraps to 0", cnt16, 0);
    ack_pulse(); idle(2);
    base = 0;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors + base, checks);
    $finish;
  end
endmodule